// File: doc/BRIEF.md
# Dual-Strobe Mode-Gated Shift Register

This block is a small parallel-out register, four bits wide by default, that the system clock samples to serve two external strobes. One strobe, the shift strobe, pushes a serial bit into stage 0 and moves every stage one place up. The other strobe, the load strobe, copies a parallel word into the register. A mode input picks which strobe is active. Both strobes and the mode input are asynchronous to the system clock, so they pass through a two-flop synchroniser. Falling edges are found by comparing the synchronised sample with the one before it.

The data inputs go through a pipeline of the same depth as the strobes. A transfer therefore uses the data as it stood just before the strobe fell. The parallel inputs can then be wired from the register's own outputs to get a left shift without a combinational loop.

The mode should only change while both strobes are low. Two other mode changes are harmless and are accepted quietly. Every remaining change sets a sticky error flag. A serial output repeats the top stage so that several instances can be chained.

Top module: `dual_strobe_shreg`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, the register and `err_o` clear to zero.
- R2: With `mode_i`=1, a falling edge on `load_stb_i` copies `par_i[i]` into `q_o[i]` for every bit i.
- R3: With `mode_i`=0, a falling edge on `shift_stb_i` sets `q_o[0]` to `ser_i` and `q_o[i]` to the old `q_o[i-1]` for i≥1.
- R4: A falling edge on the strobe that the current mode does not select leaves `q_o` unchanged.
- R5: A rising edge on either strobe leaves `q_o` unchanged.
- R6: A transfer uses the `ser_i`/`par_i` value held before the strobe fell, even if the data changes together with the fall.
- R7: A mode change while both strobes are low changes neither `q_o` nor `err_o`.
- R8: `mode_i` rising while `load_stb_i` is high changes neither `q_o` nor `err_o`, and a later fall of `load_stb_i` loads normally.
- R9: `mode_i` falling while `shift_stb_i` is high and `load_stb_i` is low changes neither `q_o` nor `err_o`, and a later fall of `shift_stb_i` shifts normally.
- R10: Any other mode change while a strobe is high leaves `q_o` unchanged and sets `err_o`, which stays at 1 until reset.
- R11: With `par_i` = {left-in bit, `q_o[WIDTH-1:1]`} and `mode_i`=1, each load strobe shifts the register toward bit 0.
- R12: `q_o` takes its new value on the third rising `clk` edge after the strobe input falls.
- R13: `ser_o` always equals `q_o[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 1 | 1 = load strobe active, 0 = shift strobe active |
| shift_stb_i | input | 1 | Asynchronous shift strobe, acts on its falling edge |
| load_stb_i | input | 1 | Asynchronous load strobe, acts on its falling edge |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel load data |
| q_o | output | WIDTH | Register contents |
| ser_o | output | 1 | Cascade output, equal to the top stage |
| err_o | output | 1 | Sticky flag for an illegal mode change |

## Verification
The hardest situations to reach are mode changes that fall inside a strobe's high phase. The outcome depends on which strobe is high and on the direction of the change. The bench raises one strobe and waits until the synchroniser has settled. It then flips the mode and lets that settle as well, and only after that lowers the strobe. This separates the quiet cases from the error cases. It also shows what the register does on the strobe fall that follows. Each error case runs after its own reset, so the sticky flag of one case cannot hide the result of the next.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  typedef enum logic [1:0] {
    MC_NONE,   // mode steady
    MC_LEGAL,  // changed with both strobes low
    MC_QUIET,  // tolerated change, no effect
    MC_BAD     // outcome would be undefined: flag it
  } mode_chg_e;

  // Classify a mode transition using the strobe levels seen before it.
  function automatic mode_chg_e classify_mode_change(
    input logic mode_prev,
    input logic mode_cur,
    input logic shift_prev,
    input logic load_prev
  );
    if (mode_prev == mode_cur)              return MC_NONE;
    if (!shift_prev && !load_prev)          return MC_LEGAL;
    if (mode_cur && load_prev)              return MC_QUIET;
    if (!mode_cur && shift_prev && !load_prev) return MC_QUIET;
    return MC_BAD;
  endfunction

endpackage

// File: rtl/dsr_delay.sv
module dsr_delay #(
  parameter int WIDTH = 1,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
    end else begin
      stage[0] <= din;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[DEPTH-1];
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
  import dsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mode_cur,
  input  logic mode_prev,
  input  logic shift_cur,
  input  logic shift_prev,
  input  logic load_cur,
  input  logic load_prev,
  output logic load_ev,
  output logic shift_ev,
  output logic err_set
);
  mode_chg_e chg;
  logic      load_fall;
  logic      shift_fall;

  assign chg        = classify_mode_change(mode_prev, mode_cur, shift_prev, load_prev);
  assign load_fall  = load_prev & ~load_cur;
  assign shift_fall = shift_prev & ~shift_cur;

  assign load_ev  = (chg == MC_NONE) &&  mode_cur && load_fall;
  assign shift_ev = (chg == MC_NONE) && !mode_cur && shift_fall;
  assign err_set  = (chg == MC_BAD);

  // A bad mode change never coincides with a transfer.
  assert_bad_change_no_transfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |-> !(load_ev || shift_ev));

  // Only a falling strobe may cause a transfer.
  assert_transfer_needs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev || shift_ev) |-> (load_prev && !load_cur) || (shift_prev && !shift_cur));
endmodule

// File: rtl/dsr_datapath.sv
module dsr_datapath #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_ev,
  input  logic             shift_ev,
  input  logic             err_set,
  input  logic             ser_d,
  input  logic [WIDTH-1:0] par_d,
  output logic [WIDTH-1:0] q,
  output logic             err
);
  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] v, input logic b);
    return {v[WIDTH-2:0], b};
  endfunction

  logic [WIDTH-1:0] q_q;
  logic             err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q   <= '0;
      err_q <= 1'b0;
    end else begin
      if (load_ev)       q_q <= par_d;
      else if (shift_ev) q_q <= shift_up(q_q, ser_d);
      err_q <= err_q | err_set;
    end
  end

  assign q   = q_q;
  assign err = err_q;

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (q_q == '0 && !err_q));

  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> q_q == $past(par_d));

  assert_shift_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |=> (q_q[0] == $past(ser_d)) && (q_q[WIDTH-1:1] == $past(q_q[WIDTH-2:0])));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ev || shift_ev) |=> $stable(q_q));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             shift_stb_i,
  input  logic             load_stb_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o,
  output logic             ser_o,
  output logic             err_o
);
  localparam int CTRL_W = 3;
  localparam int DATA_W = WIDTH + 1;
  localparam int DATA_DEPTH = SYNC_STAGES + 1;

  logic [CTRL_W-1:0] ctrl_cur, ctrl_prev;
  logic [DATA_W-1:0] data_prev;
  logic              load_ev, shift_ev, err_set;

  // Control inputs: synchronise, then keep one older sample for edges.
  dsr_delay #(.WIDTH(CTRL_W), .DEPTH(SYNC_STAGES)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .din({mode_i, shift_stb_i, load_stb_i}), .dout(ctrl_cur));

  dsr_delay #(.WIDTH(CTRL_W), .DEPTH(1)) u_ctrl_prev (
    .clk(clk), .rst_n(rst_n), .din(ctrl_cur), .dout(ctrl_prev));

  // Data follows the same path, aligned with the pre-edge control sample.
  dsr_delay #(.WIDTH(DATA_W), .DEPTH(DATA_DEPTH)) u_data_pipe (
    .clk(clk), .rst_n(rst_n), .din({ser_i, par_i}), .dout(data_prev));

  dsr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mode_cur(ctrl_cur[2]),   .mode_prev(ctrl_prev[2]),
    .shift_cur(ctrl_cur[1]),  .shift_prev(ctrl_prev[1]),
    .load_cur(ctrl_cur[0]),   .load_prev(ctrl_prev[0]),
    .load_ev(load_ev), .shift_ev(shift_ev), .err_set(err_set));

  dsr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .load_ev(load_ev), .shift_ev(shift_ev), .err_set(err_set),
    .ser_d(data_prev[WIDTH]), .par_d(data_prev[WIDTH-1:0]),
    .q(q_o), .err(err_o));

  assign ser_o = q_o[WIDTH-1];

  assert_single_transfer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ev, shift_ev}));
endmodule

// File: tb/test_dual_strobe_shreg.sv
module test_dual_strobe_shreg;
  localparam int W = 4;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0, sstb = 1'b0, lstb = 1'b0, ser = 1'b0, lin = 1'b0, fb_en = 1'b0;
  logic [W-1:0] par_reg = '0;
  logic [W-1:0] par_drv, q;
  logic ser_o, err;
  logic [W-1:0] q_exp;
  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign par_drv = fb_en ? {lin, q[W-1:1]} : par_reg;

  dual_strobe_shreg #(.WIDTH(W), .SYNC_STAGES(2)) i_dual_strobe_shreg (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .shift_stb_i(sstb), .load_stb_i(lstb),
    .ser_i(ser), .par_i(par_drv), .q_o(q), .ser_o(ser_o), .err_o(err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_load();
    lstb = 1'b1; tick(4); lstb = 1'b0; tick(5);
  endtask

  task automatic pulse_shift();
    sstb = 1'b1; tick(4); sstb = 1'b0; tick(5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 q", q, 0); chk("R1 err", err, 0);
    rst_n = 1'b1; tick(2);

    // R2 / R13: all load values
    mode = 1'b1; tick(5);
    for (int v = 0; v < 16; v++) begin
      par_reg = v[W-1:0];
      pulse_load();
      chk("R2 load", q, v);
      chk("R13 ser_o", ser_o, v[W-1]);
    end

    // R5: rising edge alone, R12: latency
    par_reg = 4'h5; lstb = 1'b1; tick(5);
    chk("R5 rise no change", q, 4'hF);
    lstb = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R12 not yet", q, 4'hF);
    @(negedge clk);
    chk("R12 third edge", q, 4'h5);
    tick(3);

    // R7: legal mode change
    mode = 1'b0; tick(5);
    chk("R7 q", q, 4'h5); chk("R7 err", err, 0);

    // R3: shift every 4-bit pattern in
    q_exp = 4'h5;
    for (int v = 0; v < 16; v++) begin
      for (int b = 0; b < W; b++) begin
        ser = v[b];
        pulse_shift();
        q_exp = {q_exp[W-2:0], v[b]};
        chk("R3 shift", q, q_exp);
      end
    end

    // R4: disabled strobe ignored in both modes
    par_reg = ~q_exp; pulse_load();
    chk("R4 load in shift mode", q, q_exp);
    mode = 1'b1; tick(5);
    ser = ~q_exp[0]; pulse_shift();
    chk("R4 shift in load mode", q, q_exp);

    // R6: data changes together with the falling strobe
    par_reg = 4'hA; lstb = 1'b1; tick(4);
    lstb = 1'b0; par_reg = 4'h3; tick(5);
    chk("R6 load pre-edge", q, 4'hA);
    mode = 1'b0; tick(5);
    ser = 1'b1; sstb = 1'b1; tick(4);
    sstb = 1'b0; ser = 1'b0; tick(5);
    chk("R6 shift pre-edge", q, 4'h5);

    // R11: left shift via feedback wiring
    mode = 1'b1; tick(5);
    par_reg = 4'hB; pulse_load();
    q_exp = 4'hB; fb_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      lin = k[0];
      pulse_load();
      q_exp = {k[0], q_exp[W-1:1]};
      chk("R11 left shift", q, q_exp);
    end
    fb_en = 1'b0;

    // R8: mode rises while load strobe high
    mode = 1'b0; tick(5);
    par_reg = 4'h6; lstb = 1'b1; tick(5);
    mode = 1'b1; tick(5);
    chk("R8 q", q, q_exp); chk("R8 err", err, 0);
    lstb = 1'b0; tick(5);
    chk("R8 later load", q, 4'h6);

    // R9: mode falls while shift strobe high, load low
    ser = 1'b1; sstb = 1'b1; tick(5);
    mode = 1'b0; tick(5);
    chk("R9 q", q, 4'h6); chk("R9 err", err, 0);
    sstb = 1'b0; tick(5);
    chk("R9 later shift", q, 4'hD);

    // R10 case a: mode rises while shift strobe high
    ser = 1'b0; sstb = 1'b1; tick(5);
    mode = 1'b1; tick(5);
    chk("R10a err", err, 1); chk("R10a q", q, 4'hD);
    sstb = 1'b0; tick(5);
    chk("R10a no shift", q, 4'hD);
    par_reg = 4'h2; pulse_load();
    chk("R10 sticky", err, 1); chk("R10 load after", q, 4'h2);
    rst_n = 1'b0; tick(3);
    chk("R1 mid q", q, 0); chk("R1 mid err", err, 0);
    rst_n = 1'b1; tick(2);

    // R10 case b: mode falls while load strobe high
    mode = 1'b1; tick(5);
    par_reg = 4'h9; pulse_load();
    par_reg = 4'h4; lstb = 1'b1; tick(5);
    mode = 1'b0; tick(5);
    chk("R10b err", err, 1); chk("R10b q", q, 4'h9);
    lstb = 1'b0; tick(5);
    chk("R10b no load", q, 4'h9);

    do_reset();
    chk("R1 final", {err, q}, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule